// File: doc/BRIEF.md
# I2C Passive Bus Monitor

This block listens to an I2C bus without ever taking part in it. It synchronises SCL and SDA to the system clock and oversamples them. It finds START and STOP conditions and assembles every 9-bit frame: eight data bits followed by the acknowledge bit. The first frame after any START is taken as an address byte. Its upper seven bits are compared with four programmable slot values, and each slot can also enable recognition of the general-call address.

Once an address has hit, every frame that follows raises a sticky interrupt until the next STOP or repeated START. This covers both write and read transfers, because the block records whatever the real target device drives. At the end of every frame, the eight data bits go into a hold register. Software then has a whole frame time to read that register before the next byte replaces it. The live shift register also stays visible. When stretching is enabled, the block can hold SCL low while an interrupt is pending. It never drives SDA.

Top module: `i2c_bus_observer`

## Requirements
- R1: After reset, irq_o, overrun_o, matched_o, scl_hold_o, hold_o and shift_o are all zero.
- R2: On the rising SCL edge of the ninth bit of every frame, hold_o loads the eight data bits of that frame, MSB first on the wire, whether or not an address has matched. At all other times hold_o keeps its value.
- R3: shift_o shows the last eight bits sampled on rising SCL edges, with the newest bit in bit 0. After a complete frame it equals {data[6:0], ack}.
- R4: A slot is a byte whose bits 7:1 hold an address and whose bit 0 enables general call. The address byte hits a slot when the slot's address field is nonzero and equals bits 7:1 of the byte. A slot equal to 0x00 never hits. When several slots hit, the lowest index wins, and match_idx_o reports it.
- R5: A slot with bit 0 set hits any address byte whose bits 7:1 are zero.
- R6: A hit address frame sets irq_o and matched_o. Each later frame sets irq_o while matched_o is 1. An address that misses sets neither.
- R7: irq_o stays set until a cycle with irq_clr_i high clears it. If a new frame completes in the same cycle as a clear, irq_o stays set.
- R8: overrun_o is set when an interrupt-raising frame completes while irq_o is still pending and not being cleared. irq_clr_i clears it.
- R9: rw_o takes bit 0 of the address byte when that byte hits.
- R10: A STOP clears matched_o. A repeated START clears it too, and the next frame is treated as an address byte.
- R11: scl_hold_o is 1 only while stretch_en_i is 1, irq_o is pending and the synchronised SCL is low. It releases after the interrupt is cleared. With stretch_en_i low, it stays 0.
- R12: sda_oe_o is never asserted.
- R13: A START in the middle of a frame discards the partial bits. The next nine bits form a complete frame, and the partial bits leave hold_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin |
| slave_addr_i | input | 32 | Four slot bytes; slot k is at bits 8k+7:8k |
| stretch_en_i | input | 1 | Allows SCL to be held low while an interrupt is pending |
| irq_clr_i | input | 1 | Clears the interrupt and the overrun flag |
| scl_hold_o | output | 1 | Request to pull SCL low |
| sda_oe_o | output | 1 | SDA drive enable, always low |
| irq_o | output | 1 | Per-frame interrupt after an address hit |
| shift_o | output | 8 | Live shift register |
| hold_o | output | 8 | Byte captured at the end of each frame |
| overrun_o | output | 1 | Hold byte was replaced while an interrupt was pending |
| matched_o | output | 1 | An address hit is active for the current transfer |
| match_idx_o | output | 2 | Index of the slot that hit |
| rw_o | output | 1 | Direction bit of the address byte that hit |

## Verification
The address compare is driven with bytes built from the configured slot fields and with random bytes. The bench predicts each outcome from its own slot model, so it can tell a correct hit from a missed hit, a false hit, or the wrong priority when two slots hold the same address. General-call bytes are sent both with the enable bit clear and with it set, to separate the two cases. Data frames carry random payloads and random acknowledge bits, which exposes errors in bit order, in frame alignment and in the ACK position of the shift register. Directed sequences cover repeated START, a START in mid-frame, a missing interrupt clear (for overrun) and stretching with the enable on and off.

// File: rtl/obs_pkg.sv
`timescale 1ns/1ps
package obs_pkg;
    localparam int BYTE_W  = 8;
    localparam int FRAME_W = BYTE_W + 1;
    localparam int ADDR_W  = BYTE_W - 1;

    // Slot byte: [7:1] address, [0] general-call enable
    function automatic logic slot_hit(input logic [BYTE_W-1:0] slot,
                                      input logic [ADDR_W-1:0] addr);
        logic dir_hit;
        logic gc_hit;
        dir_hit = (slot[BYTE_W-1:1] != '0) && (slot[BYTE_W-1:1] == addr);
        gc_hit  = slot[0] && (addr == '0);
        return dir_hit || gc_hit;
    endfunction
endpackage

// File: rtl/obs_line_sync.sv
`timescale 1ns/1ps
module obs_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s_o,
    output logic sda_s_o,
    output logic scl_rise_o,
    output logic start_o,
    output logic stop_o
);
    localparam int ST = (STAGES < 2) ? 2 : STAGES;

    typedef struct packed {
        logic [ST-1:0] scl_pipe;
        logic [ST-1:0] sda_pipe;
        logic          scl_p;
        logic          sda_p;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d          = q;
        d.scl_pipe = {q.scl_pipe[ST-2:0], scl_i};
        d.sda_pipe = {q.sda_pipe[ST-2:0], sda_i};
        d.scl_p    = q.scl_pipe[ST-1];
        d.sda_p    = q.sda_pipe[ST-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '1;
        end else begin
            q <= d;
        end
    end

    assign scl_s_o    = q.scl_pipe[ST-1];
    assign sda_s_o    = q.sda_pipe[ST-1];
    assign scl_rise_o = scl_s_o & ~q.scl_p;
    assign start_o    = scl_s_o & q.scl_p & q.sda_p & ~sda_s_o;
    assign stop_o     = scl_s_o & q.scl_p & ~q.sda_p & sda_s_o;
endmodule

// File: rtl/obs_addr_match.sv
`timescale 1ns/1ps
module obs_addr_match
    import obs_pkg::*;
#(
    parameter int SLOTS = 4,
    localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic [SLOTS*BYTE_W-1:0] slots_i,
    input  logic [ADDR_W-1:0]       addr_i,
    output logic                    hit_o,
    output logic [IDX_W-1:0]        idx_o
);
    logic [SLOTS-1:0] slot_hits;

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        assign slot_hits[g] = slot_hit(slots_i[g*BYTE_W +: BYTE_W], addr_i);
    end

    always_comb begin
        hit_o = |slot_hits;
        idx_o = '0;
        for (int k = SLOTS - 1; k >= 0; k--) begin
            if (slot_hits[k]) begin
                idx_o = IDX_W'(k);
            end
        end
    end

    always_comb begin
        if (hit_o) begin
            AST_ZERO_SLOT_SILENT: assert (slots_i[idx_o*BYTE_W +: BYTE_W] != '0); // R4
        end
    end
endmodule

// File: rtl/obs_framer.sv
`timescale 1ns/1ps
module obs_framer
    import obs_pkg::*;
#(
    parameter int SLOTS = 4,
    localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int CNT_W = $clog2(FRAME_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise_i,
    input  logic              sda_s_i,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              irq_clr_i,
    input  logic              hit_i,
    input  logic [IDX_W-1:0]  hit_idx_i,
    output logic [BYTE_W-1:0] shift_o,
    output logic [BYTE_W-1:0] hold_o,
    output logic              irq_o,
    output logic              ovr_o,
    output logic              matched_o,
    output logic [IDX_W-1:0]  idx_o,
    output logic              rw_o
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] shift;
        logic [BYTE_W-1:0] hold;
        logic              active;
        logic              in_addr;
        logic              matched;
        logic [IDX_W-1:0]  idx;
        logic              rw;
        logic              irq;
        logic              ovr;
    } frm_t;

    frm_t q, d;
    logic fire;
    logic frame_end;

    assign frame_end = scl_rise_i && q.active && (q.cnt == LAST_BIT);

    always_comb begin
        d    = q;
        fire = 1'b0;
        if (irq_clr_i) begin
            d.irq = 1'b0;
            d.ovr = 1'b0;
        end
        if (start_i) begin
            d.cnt     = '0;
            d.active  = 1'b1;
            d.in_addr = 1'b1;
            d.matched = 1'b0;
        end else if (stop_i) begin
            d.cnt     = '0;
            d.active  = 1'b0;
            d.in_addr = 1'b0;
            d.matched = 1'b0;
        end else if (scl_rise_i && q.active) begin
            d.shift = {q.shift[BYTE_W-2:0], sda_s_i};
            if (q.cnt == LAST_BIT) begin
                d.cnt  = '0;
                d.hold = q.shift;
                if (q.in_addr) begin
                    d.in_addr = 1'b0;
                    d.matched = hit_i;
                    fire      = hit_i;
                    if (hit_i) begin
                        d.idx = hit_idx_i;
                        d.rw  = q.shift[0];
                    end
                end else begin
                    fire = q.matched;
                end
                if (fire) begin
                    if (q.irq && !irq_clr_i) begin
                        d.ovr = 1'b1;
                    end
                    d.irq = 1'b1;
                end
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign shift_o   = q.shift;
    assign hold_o    = q.hold;
    assign irq_o     = q.irq;
    assign ovr_o     = q.ovr;
    assign matched_o = q.matched;
    assign idx_o     = q.idx;
    assign rw_o      = q.rw;

    AST_IRQ_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> matched_o); // R6
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !irq_clr_i) |=> irq_o); // R7
    AST_STOP_UNMATCH: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> !matched_o); // R10
    AST_HOLD_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_end |=> $stable(hold_o)); // R2
    AST_OVR_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_o) |-> $past(irq_o)); // R8
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= LAST_BIT); // R13
endmodule

// File: rtl/i2c_bus_observer.sv
`timescale 1ns/1ps
module i2c_bus_observer
    import obs_pkg::*;
#(
    parameter int SLOTS       = 4,
    parameter int SYNC_STAGES = 2,
    localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    scl_i,
    input  logic                    sda_i,
    input  logic [SLOTS*BYTE_W-1:0] slave_addr_i,
    input  logic                    stretch_en_i,
    input  logic                    irq_clr_i,
    output logic                    scl_hold_o,
    output logic                    sda_oe_o,
    output logic                    irq_o,
    output logic [BYTE_W-1:0]       shift_o,
    output logic [BYTE_W-1:0]       hold_o,
    output logic                    overrun_o,
    output logic                    matched_o,
    output logic [IDX_W-1:0]        match_idx_o,
    output logic                    rw_o
);
    logic scl_s, sda_s, scl_rise, start_c, stop_c;
    logic hit;
    logic [IDX_W-1:0] hit_idx;

    obs_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s_o   (scl_s),
        .sda_s_o   (sda_s),
        .scl_rise_o(scl_rise),
        .start_o   (start_c),
        .stop_o    (stop_c)
    );

    obs_addr_match #(.SLOTS(SLOTS)) u_match (
        .slots_i(slave_addr_i),
        .addr_i (shift_o[BYTE_W-1:1]),
        .hit_o  (hit),
        .idx_o  (hit_idx)
    );

    obs_framer #(.SLOTS(SLOTS)) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise_i(scl_rise),
        .sda_s_i   (sda_s),
        .start_i   (start_c),
        .stop_i    (stop_c),
        .irq_clr_i (irq_clr_i),
        .hit_i     (hit),
        .hit_idx_i (hit_idx),
        .shift_o   (shift_o),
        .hold_o    (hold_o),
        .irq_o     (irq_o),
        .ovr_o     (overrun_o),
        .matched_o (matched_o),
        .idx_o     (match_idx_o),
        .rw_o      (rw_o)
    );

    // Pull SCL low only after the master has already lowered it
    assign scl_hold_o = stretch_en_i & irq_o & ~scl_s;
    assign sda_oe_o   = 1'b0;
endmodule

// File: tb/sim_i2c_bus_observer.sv
`timescale 1ns/1ps
module sim_i2c_bus_observer;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst_n, scl_drv, sda_drv, stretch_en, irq_clr;
    logic [31:0] cfg;
    logic        scl_hold, sda_oe, irq, ovr, matched, rw;
    logic [7:0]  shift, hold;
    logic [1:0]  midx;
    wire         bus_scl = scl_drv & ~scl_hold;
    wire         bus_sda = sda_drv & ~sda_oe;

    int checks = 0;
    int errors = 0;
    int sda_drive_seen = 0;

    i2c_bus_observer u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(bus_scl), .sda_i(bus_sda),
        .slave_addr_i(cfg), .stretch_en_i(stretch_en), .irq_clr_i(irq_clr),
        .scl_hold_o(scl_hold), .sda_oe_o(sda_oe), .irq_o(irq), .shift_o(shift),
        .hold_o(hold), .overrun_o(ovr), .matched_o(matched),
        .match_idx_o(midx), .rw_o(rw)
    );

    always @(negedge clk) if (sda_oe) sda_drive_seen++;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [2:0] model(input logic [7:0] b);
        for (int k = 0; k < 4; k++) begin
            logic [7:0] s;
            s = cfg[k*8 +: 8];
            if ((s[7:1] != 0 && s[7:1] == b[7:1]) || (s[0] && b[7:1] == 0))
                return {1'b1, 2'(k)};
        end
        return 3'b000;
    endfunction

    task automatic qw();
        repeat (4) @(posedge clk);
    endtask

    task automatic bus_start();
        sda_drv = 1'b1; qw();
        scl_drv = 1'b1;
        while (!bus_scl) @(posedge clk);
        qw();
        sda_drv = 1'b0; qw();
        scl_drv = 1'b0; qw();
    endtask

    task automatic bus_bit(input logic b);
        sda_drv = b; qw();
        scl_drv = 1'b1;
        while (!bus_scl) @(posedge clk);
        qw(); qw();
        scl_drv = 1'b0; qw();
    endtask

    task automatic bus_stop();
        sda_drv = 1'b0; qw();
        scl_drv = 1'b1;
        while (!bus_scl) @(posedge clk);
        qw();
        sda_drv = 1'b1; qw();
    endtask

    task automatic send_byte(input logic [7:0] b, input logic ack);
        for (int i = 7; i >= 0; i--) bus_bit(b[i]);
        bus_bit(ack);
        @(negedge clk);
    endtask

    task automatic clear_irq();
        @(negedge clk) irq_clr = 1'b1;
        @(negedge clk) irq_clr = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [2:0] m;
        logic [7:0] b;
        int unsigned seed;
        seed = $urandom(32'd918273);
        rst_n = 1'b0; scl_drv = 1'b1; sda_drv = 1'b1;
        stretch_en = 1'b0; irq_clr = 1'b0; cfg = 32'h0;
        repeat (10) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(irq == 0 && ovr == 0 && matched == 0 && scl_hold == 0, "R1 flags",
            {irq, ovr, matched, scl_hold}, 0);
        chk(hold == 0 && shift == 0, "R1 data", {hold, shift}, 0);

        // All slots zero: nothing matches, hold still loads
        bus_start();
        send_byte(8'hA4, 1'b1);
        chk(irq == 0 && matched == 0, "R4 zero slots", {irq, matched}, 0);
        chk(hold == 8'hA4, "R2 unmatched load", hold, 8'hA4);
        bus_stop();
        bus_start();
        send_byte(8'h00, 1'b0);
        chk(irq == 0 && matched == 0, "R5 gc disabled", {irq, matched}, 0);
        bus_stop();

        // slot0 off, slot1 0x52, slot2 gc only, slot3 0x52 with gc
        cfg = 32'hA5_01_A4_00;
        bus_start();
        send_byte(8'hA5, 1'b0);
        chk(irq == 1 && matched == 1, "R6 address hit", {irq, matched}, 2'b11);
        chk(midx == 2'd1, "R4 lowest index", midx, 1);
        chk(rw == 1, "R9 read direction", rw, 1);
        clear_irq();
        chk(irq == 0, "R7 cleared", irq, 0);
        send_byte(8'h3C, 1'b1);
        chk(irq == 1 && hold == 8'h3C, "R6 data irq", {irq, hold}, {1'b1, 8'h3C});
        chk(shift == 8'h79, "R3 shift with ack", shift, 8'h79);
        repeat (50) @(posedge clk);
        @(negedge clk);
        chk(irq == 1, "R7 sticky", irq, 1);
        send_byte(8'hC3, 1'b1);
        chk(ovr == 1 && hold == 8'hC3, "R8 overrun", {ovr, hold}, {1'b1, 8'hC3});
        clear_irq();
        chk(ovr == 0 && irq == 0, "R8 cleared", {ovr, irq}, 0);
        bus_stop();
        @(negedge clk);
        chk(matched == 0, "R10 stop", matched, 0);

        // General call, then repeated START to a miss
        bus_start();
        send_byte(8'h01, 1'b0);
        chk(irq == 1 && midx == 2'd2 && rw == 1, "R5 general call", {irq, midx, rw}, {1'b1, 2'd2, 1'b1});
        clear_irq();
        bus_start();
        send_byte(8'h40, 1'b1);
        chk(matched == 0 && irq == 0, "R10 repeated start", {matched, irq}, 0);
        bus_stop();

        // START in mid-frame
        bus_start();
        send_byte(8'hA4, 1'b0);
        clear_irq();
        for (int i = 0; i < 5; i++) bus_bit(1'b1);
        @(negedge clk);
        chk(hold == 8'hA4, "R13 partial keeps hold", hold, 8'hA4);
        bus_start();
        send_byte(8'h02, 1'b1);
        chk(hold == 8'h02 && shift == 8'h05, "R13 realigned", {hold, shift}, {8'h02, 8'h05});
        chk(matched == 0 && irq == 0, "R13 miss after restart", {matched, irq}, 0);
        bus_stop();

        // Stretching
        stretch_en = 1'b1;
        bus_start();
        send_byte(8'hA4, 1'b0);
        chk(scl_hold == 1 && bus_scl == 0, "R11 hold asserted", {scl_hold, bus_scl}, 2'b10);
        repeat (40) @(posedge clk);
        @(negedge clk);
        chk(scl_hold == 1, "R11 hold persists", scl_hold, 1);
        clear_irq();
        chk(scl_hold == 0, "R11 released", scl_hold, 0);
        stretch_en = 1'b0;
        send_byte(8'h55, 1'b1);
        chk(irq == 1 && scl_hold == 0, "R11 disabled", {irq, scl_hold}, 2'b10);
        clear_irq();
        bus_stop();

        // Random transfers
        for (int t = 0; t < 40; t++) begin
            int n;
            if ($urandom % 2) begin
                int k;
                k = 1 + ($urandom % 3);
                b = {cfg[k*8+1 +: 7], 1'($urandom)};
            end else begin
                b = 8'($urandom);
            end
            m = model(b);
            bus_start();
            send_byte(b, 1'($urandom));
            chk(irq == m[2] && matched == m[2], "R6 random address", {irq, matched}, {m[2], m[2]});
            chk(hold == b, "R2 random address byte", hold, b);
            if (m[2]) begin
                chk(midx == m[1:0] && rw == b[0], "R4 R9 random index", {midx, rw}, {m[1:0], b[0]});
            end
            clear_irq();
            n = 1 + ($urandom % 3);
            for (int j = 0; j < n; j++) begin
                logic [7:0] db;
                logic a;
                db = 8'($urandom);
                a = 1'($urandom);
                send_byte(db, a);
                chk(hold == db && irq == m[2], "R2 R6 random data", {irq, hold}, {m[2], db});
                chk(shift == {db[6:0], a}, "R3 random shift", shift, {db[6:0], a});
                clear_irq();
            end
            bus_stop();
            @(negedge clk);
            chk(matched == 0, "R10 random stop", matched, 0);
        end

        chk(sda_drive_seen == 0, "R12 no sda drive", sda_drive_seen, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule